// File: doc/BRIEF.md
# Cumulative Lamp-Group Sign Sequencer

This block sequences a five-lamp arrow-style warning sign. The lamps are wired as three drive groups: the first pair, the second pair, and the single tip lamp. While the enable switch is on, the sign builds up one group per step. It goes from dark to the first pair, then to both pairs, then to everything lit, and then goes dark again to repeat. When the switch is off, the sign is blank at the next clock, whatever step it had reached.

The block is a Moore machine: the group drives depend only on the stored step level. A step-enable input, usually a slow tick from elsewhere, gates the advance so that the build-up is visible to the eye. Parameters set the number of lamp groups and whether the step-enable is honoured or ignored. They also select whether the level is stored as a compact binary count with a decoder, or as a thermometer word that drives the lamps directly.

Top module: `arrow_sign_seq`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge leaves every bit of `grp_drive` low after that edge.
- R2: When `sw_on` is 0 at a clock edge, `grp_drive` is all zeros after that edge, regardless of the current level and of `step_en`.
- R3: With `sw_on` high and an advance permitted, the level rises by one per clock edge, so `grp_drive` goes 000, 001, 011, 111. Bit 0 is lamps 1 and 2, bit 1 is lamps 3 and 4, and bit 2 is lamp 5.
- R4: From the fully lit level (all ones), an advance returns `grp_drive` to all zeros.
- R5: With `USE_STEP_EN`=1, `sw_on` high and `step_en` low at an edge, `grp_drive` keeps its value.
- R6: `grp_drive` is always a thermometer code. Bit 0 is high in levels 1 to 3, bit 1 is high in levels 2 and 3, and bit 2 is high only in level 3.
- R7: After the switch turns on from blank, the first group appears exactly one permitted-advance edge later.
- R8: With `USE_STEP_EN`=0, `step_en` has no effect and the sign advances on every edge while `sw_on` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_on | input | 1 | Sign enable switch; 0 blanks the sign at the next edge |
| step_en | input | 1 | Advance permission tick (used when USE_STEP_EN=1) |
| grp_drive | output | NUM_GROUPS | Lamp group drives, bit 0 = first pair, top bit = tip lamp |

## Verification
The bench builds two instances side by side. The first uses the defaults: three groups, binary storage and the step-enable honoured. With it, the hold-on-low-tick behaviour and its interaction with switch-off can be reached. The second uses three groups with thermometer storage and the step-enable ignored. It exercises the other storage variant and shows that the tick has no effect there, under the same stimulus that makes the first instance hold.

// File: rtl/sign_seq_pkg.sv
package sign_seq_pkg;
   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_STEP  = 2'd1,
      ACT_BLANK = 2'd2
   } sign_act_e;
endpackage

// File: rtl/sign_next_ctl.sv
module sign_next_ctl
   import sign_seq_pkg::*;
#(
   parameter int USE_STEP_EN = 1
) (
   input  logic      rst,
   input  logic      sw_on,
   input  logic      step_en,
   output sign_act_e act
);
   logic go;

   generate
      if (USE_STEP_EN != 0) begin : g_gated
         assign go = step_en;
      end else begin : g_free
         logic unused_step_en;
         assign unused_step_en = step_en;
         assign go = 1'b1;
      end
   endgenerate

   // Switch-off and reset both win over any advance.
   always_comb begin
      if (rst || !sw_on)
         act = ACT_BLANK;
      else if (go)
         act = ACT_STEP;
      else
         act = ACT_HOLD;
   end
endmodule

// File: rtl/sign_lamp_decode.sv
module sign_lamp_decode #(
   parameter int NUM_GROUPS = 3,
   localparam int LVL_W = $clog2(NUM_GROUPS + 1)
) (
   input  logic [LVL_W-1:0]      level,
   output logic [NUM_GROUPS-1:0] lamps
);
   generate
      for (genvar i = 0; i < NUM_GROUPS; i++) begin : g_grp
         assign lamps[i] = (level > LVL_W'(i));
      end
   endgenerate
endmodule

// File: rtl/sign_level_store.sv
module sign_level_store
   import sign_seq_pkg::*;
#(
   parameter int NUM_GROUPS   = 3,
   parameter int THERMO_STORE = 0
) (
   input  logic                  clk,
   input  sign_act_e             act,
   output logic [NUM_GROUPS-1:0] lamps
);
   localparam int LVL_W = $clog2(NUM_GROUPS + 1);

   generate
      if (THERMO_STORE != 0) begin : g_thermo
         logic [NUM_GROUPS-1:0] therm_q;
         always_ff @(posedge clk) begin
            case (act)
               ACT_BLANK: therm_q <= '0;
               ACT_STEP:  therm_q <= (&therm_q) ? '0 : {therm_q[NUM_GROUPS-2:0], 1'b1};
               default:   therm_q <= therm_q;
            endcase
         end
         assign lamps = therm_q;
      end else begin : g_binary
         localparam logic [LVL_W-1:0] TOP_LVL = LVL_W'(NUM_GROUPS);
         logic [LVL_W-1:0] lvl_q;
         always_ff @(posedge clk) begin
            case (act)
               ACT_BLANK: lvl_q <= '0;
               ACT_STEP:  lvl_q <= (lvl_q == TOP_LVL) ? '0 : lvl_q + 1'b1;
               default:   lvl_q <= lvl_q;
            endcase
         end
         sign_lamp_decode #(.NUM_GROUPS(NUM_GROUPS)) u_dec (
            .level (lvl_q),
            .lamps (lamps)
         );
      end
   endgenerate
endmodule

// File: rtl/arrow_sign_seq.sv
module arrow_sign_seq
   import sign_seq_pkg::*;
#(
   parameter int NUM_GROUPS   = 3,
   parameter int USE_STEP_EN  = 1,
   parameter int THERMO_STORE = 0
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic                  sw_on,
   input  logic                  step_en,
   output logic [NUM_GROUPS-1:0] grp_drive
);
   generate
      if (NUM_GROUPS < 2) begin : g_bad_groups
         $error("arrow_sign_seq: NUM_GROUPS must be at least 2");
      end
      if (USE_STEP_EN < 0 || USE_STEP_EN > 1) begin : g_bad_step
         $error("arrow_sign_seq: USE_STEP_EN must be 0 or 1");
      end
      if (THERMO_STORE < 0 || THERMO_STORE > 1) begin : g_bad_store
         $error("arrow_sign_seq: THERMO_STORE must be 0 or 1");
      end
   endgenerate

   sign_act_e act;

   sign_next_ctl #(.USE_STEP_EN(USE_STEP_EN)) u_ctl (
      .rst     (rst),
      .sw_on   (sw_on),
      .step_en (step_en),
      .act     (act)
   );

   sign_level_store #(
      .NUM_GROUPS   (NUM_GROUPS),
      .THERMO_STORE (THERMO_STORE)
   ) u_store (
      .clk   (clk),
      .act   (act),
      .lamps (grp_drive)
   );
endmodule

// File: rtl/sign_seq_chk.sv
module sign_seq_chk #(
   parameter int NUM_GROUPS  = 3,
   parameter int USE_STEP_EN = 1
) (
   input logic                  clk,
   input logic                  rst,
   input logic                  sw_on,
   input logic                  step_en,
   input logic [NUM_GROUPS-1:0] grp_drive
);
   localparam logic [NUM_GROUPS-1:0] FULL = '1;
   logic adv;
   assign adv = (USE_STEP_EN == 0) || step_en;

   a_r1_reset_blank: assert property (@(posedge clk)
      rst |=> grp_drive == '0);

   a_r2_switch_off_blank: assert property (@(posedge clk) disable iff (rst)
      !sw_on |=> grp_drive == '0);

   a_r3_one_step: assert property (@(posedge clk) disable iff (rst)
      (sw_on && adv && grp_drive != FULL)
      |=> grp_drive == NUM_GROUPS'({$past(grp_drive), 1'b1}));

   a_r4_wrap_dark: assert property (@(posedge clk) disable iff (rst)
      (sw_on && adv && grp_drive == FULL) |=> grp_drive == '0);

   a_r6_thermo_code: assert property (@(posedge clk) disable iff (rst)
      ((grp_drive + 1'b1) & grp_drive) == '0);

   generate
      if (USE_STEP_EN != 0) begin : g_gated
         a_r5_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
            (sw_on && !step_en) |=> $stable(grp_drive));
      end else begin : g_free
         a_r8_tick_ignored: assert property (@(posedge clk) disable iff (rst)
            (sw_on && !step_en) |=> grp_drive != $past(grp_drive));
      end
   endgenerate
endmodule

bind arrow_sign_seq sign_seq_chk #(
   .NUM_GROUPS  (NUM_GROUPS),
   .USE_STEP_EN (USE_STEP_EN)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .sw_on     (sw_on),
   .step_en   (step_en),
   .grp_drive (grp_drive)
);

// File: tb/arrow_sign_seq_test.sv
module arrow_sign_seq_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic sw_on = 1'b0;
   logic step_en = 1'b0;
   logic [2:0] drv_a, drv_b;

   int checks = 0;
   int failures = 0;
   int lvl_a = 0;
   int lvl_b = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   arrow_sign_seq #(.NUM_GROUPS(3), .USE_STEP_EN(1), .THERMO_STORE(0)) uut (
      .clk(clk), .rst(rst), .sw_on(sw_on), .step_en(step_en), .grp_drive(drv_a));

   arrow_sign_seq #(.NUM_GROUPS(3), .USE_STEP_EN(0), .THERMO_STORE(1)) uut_th (
      .clk(clk), .rst(rst), .sw_on(sw_on), .step_en(step_en), .grp_drive(drv_b));

   function automatic logic [2:0] expect_of(int lvl);
      logic [2:0] e;
      for (int i = 0; i < 3; i++) e[i] = (lvl > i);
      return e;
   endfunction

   function automatic int next_lvl(int lvl, bit r, bit sw, bit go);
      if (r || !sw) return 0;
      if (go) return (lvl + 1) % 4;
      return lvl;
   endfunction

   task automatic compare(string tag, string which, logic [2:0] act, int lvl);
      logic [2:0] exp_v;
      exp_v = expect_of(lvl);
      checks++;
      if (act !== exp_v) begin
         failures++;
         $display("FAIL %s %s: grp_drive=%b expected=%b", tag, which, act, exp_v);
      end
   endtask

   // Apply inputs for one edge, update the model, compare after the edge.
   task automatic cyc(bit r, bit sw, bit en, string tag_a, string tag_b);
      rst = r; sw_on = sw; step_en = en;
      @(posedge clk);
      lvl_a = next_lvl(lvl_a, r, sw, en);
      lvl_b = next_lvl(lvl_b, r, sw, 1'b1);
      @(negedge clk);
      compare(tag_a, "uut", drv_a, lvl_a);
      compare(tag_b, "uut_th", drv_b, lvl_b);
   endtask

   initial begin
      logic [7:0] lfsr;
      @(negedge clk);
      cyc(1, 0, 0, "R1", "R1");
      cyc(1, 1, 1, "R1", "R1");
      // first enabled edge after switch-on shows the first pair
      cyc(0, 1, 1, "R7", "R7");
      cyc(0, 1, 1, "R3", "R3");
      cyc(0, 1, 1, "R6", "R6");
      cyc(0, 1, 1, "R4", "R4");
      // switch on, tick low: default holds, ungated keeps stepping
      cyc(0, 1, 1, "R3", "R3");
      cyc(0, 1, 0, "R5", "R8");
      cyc(0, 1, 0, "R5", "R8");
      cyc(0, 1, 1, "R3", "R8");
      cyc(0, 1, 0, "R5", "R8");
      // switch off with tick low and high
      cyc(0, 0, 0, "R2", "R2");
      cyc(0, 1, 1, "R7", "R7");
      cyc(0, 1, 1, "R3", "R3");
      cyc(0, 0, 1, "R2", "R2");
      cyc(0, 0, 1, "R2", "R2");
      // tick high before switch-on does not pre-step
      cyc(0, 1, 0, "R7", "R8");
      cyc(0, 1, 1, "R7", "R8");
      // reset mid-run
      cyc(0, 1, 1, "R3", "R3");
      cyc(1, 1, 1, "R1", "R1");
      // mixed patterns
      lfsr = 8'hA5;
      for (int k = 0; k < 400; k++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cyc(lfsr[7:1] == 7'd0, lfsr[2:0] != 3'd0, lfsr[4] | lfsr[6], "R6", "R6");
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      #(200000 * 4);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule